// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller gathers interrupt requests from a group of on-chip peripheral sources and two external request lines. It drives one normal interrupt output towards a processor. A second output, the fast interrupt, has its own path: it follows a single dedicated external input and nothing else. Each source has its own enable, a priority from 0 to 7 and a trigger mode. The winning source number and its programmed vector are presented combinationally while the normal interrupt is raised.

Software programs each source through a one-cycle configuration write port. It takes an interrupt by pulsing `ack`, which stands for the vector read. It finishes the handler by pulsing `eoi`. Each acknowledge saves the level it accepted on an internal stack. While that level is in service, only a strictly higher level can interrupt it, so handlers nest by priority. Each end-of-interrupt removes the newest saved level. The three asynchronous external inputs pass through two-flop synchronizers before any detection. Internal sources are sampled directly.

Top module: `prio_vic`

## Requirements
- R1: While `rst_n` is low and after reset, the outputs are `irq_o`=0, `fiq_o`=0, `src_o`=0 and `vec_o`=0, every source is disabled with priority 0 and mode 0, and the level stack is empty.
- R2: `fiq_o` equals `ext_fiq` as sampled two rising clock edges earlier. No peripheral source, external request line, configuration write, acknowledge or end-of-interrupt affects it.
- R3: `irq_o` is 1 exactly when at least one source is eligible. When it is 1, `src_o` gives the winning source number and `vec_o` gives the vector programmed for that source. When it is 0, both `src_o` and `vec_o` are 0.
- R4: Source numbers 0 to NI-1 are the internal sources, with bit i of `per_irq` feeding source i. Source NI is `ext_irq[0]` and source NI+1 is `ext_irq[1]`. Among eligible sources the largest priority value wins (7 is highest). On a tie, the lower source number wins.
- R5: Mode field `cfg_mode` works as follows. Bit 0 set to 1 selects edge triggering and set to 0 selects level sensitivity. For external sources, bit 1 set to 1 selects active-low level or falling edge, and set to 0 selects active-high level or rising edge. Internal sources ignore bit 1, so their levels are always active-high and their edges always rising.
- R6: A level-sensitive source requests for as long as its active level is present and holds no memory. An internal source acts in the same cycle. An external line acts after its two-flop synchronizer, which means two clock edges later.
- R7: An edge-triggered source latches a pending bit on its active edge. This happens even while the source is disabled. The bit stays set until an acknowledge in which that source is the winner. If a new edge arrives in that same cycle, the bit is set again.
- R8: A disabled source never wins and never raises `irq_o`.
- R9: An acknowledge while `irq_o` is 1 pushes the winner's priority onto the stack. While the stack is not empty, a source is eligible only if its priority is strictly greater than the newest saved level. An acknowledge while `irq_o` is 0 is ignored.
- R10: An end-of-interrupt pops the newest saved level. An end-of-interrupt with an empty stack is ignored. When `ack` and `eoi` are both high in the same cycle, the acknowledge is ignored entirely: nothing is pushed and no pending bit is cleared.
- R11: A configuration write with `cfg_we`=1 updates enable, priority, mode and vector of source `cfg_src` at the next edge. A write whose `cfg_src` is NI+2 or greater changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_irq | input | NI | Internal peripheral request lines, synchronous |
| ext_irq | input | 2 | External request lines, asynchronous |
| ext_fiq | input | 1 | External fast request, asynchronous, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | $clog2(NI+3) | Source number written |
| cfg_en | input | 1 | Enable value written |
| cfg_prio | input | $clog2(NL) | Priority value written |
| cfg_mode | input | 2 | Trigger mode written |
| cfg_vec | input | VW | Vector value written |
| ack | input | 1 | Vector read / acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| src_o | output | $clog2(NI+3) | Winning source number |
| vec_o | output | VW | Vector of the winning source |

## Verification
The hardest states to reach from the ports are a deeply filled level stack and an edge that is latched while its source is masked and then surfaces later. An unwanted ordering of acknowledge and end-of-interrupt pulses easily hides both. Directed sequences build a nesting ladder: a level source is acknowledged, equal and lower priorities are shown to be blocked, and a higher one preempts. They also disable an edge source, pulse it, and re-enable it. A long random phase then applies acknowledges more often than end-of-interrupts and rewrites the configuration occasionally, including at indices out of range. This pushes the stack towards its full depth while a behavioural model is compared against the outputs every cycle.

// File: rtl/prio_vic.sv
module prio_vic #(
  parameter int NI = 6,
  parameter int NL = 8,
  parameter int VW = 16,
  localparam int NS = NI + 2,
  localparam int SW = $clog2(NS + 1),
  localparam int PW = $clog2(NL),
  localparam int DW = $clog2(NL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NI-1:0] per_irq,
  input  logic [1:0]    ext_irq,
  input  logic          ext_fiq,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_src,
  input  logic          cfg_en,
  input  logic [PW-1:0] cfg_prio,
  input  logic [1:0]    cfg_mode,
  input  logic [VW-1:0] cfg_vec,
  input  logic          ack,
  input  logic          eoi,
  output logic          irq_o,
  output logic          fiq_o,
  output logic [SW-1:0] src_o,
  output logic [VW-1:0] vec_o
);

  logic [NS-1:0] en_q, pend_q, low, act, ev, req, elig, now_v, prev_v;
  logic [PW-1:0] prio_q [NS];
  logic [1:0]    mode_q [NS];
  logic [VW-1:0] vec_q  [NS];
  logic [1:0]    ext_m, ext_s, ext_d;
  logic [NI-1:0] per_d;
  logic          fiq_m, fiq_s;
  logic [PW-1:0] stk_q [NL];
  logic [DW-1:0] depth_q;
  logic [PW-1:0] top_lvl, wp;
  logic [SW-1:0] win;
  logic          hit, take, pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_m <= '0; ext_s <= '0; ext_d <= '0;
      per_d <= '0; fiq_m <= 1'b0; fiq_s <= 1'b0;
    end else begin
      ext_m <= ext_irq; ext_s <= ext_m; ext_d <= ext_s;
      per_d <= per_irq; fiq_m <= ext_fiq; fiq_s <= fiq_m;
    end
  end

  assign now_v   = {ext_s, per_irq};
  assign prev_v  = {ext_d, per_d};
  assign top_lvl = stk_q[PW'(depth_q - DW'(1))];
  assign pop     = eoi & (depth_q != '0);
  assign take    = ack & ~eoi & hit;

  for (genvar i = 0; i < NS; i++) begin : g_src
    localparam bit EXT = (i >= NI);
    assign low[i]  = EXT & mode_q[i][1];
    assign act[i]  = now_v[i] ^ low[i];
    assign ev[i]   = low[i] ? (prev_v[i] & ~now_v[i]) : (now_v[i] & ~prev_v[i]);
    assign req[i]  = mode_q[i][0] ? pend_q[i] : act[i];
    assign elig[i] = req[i] & en_q[i] & ((depth_q == '0) || (prio_q[i] > top_lvl));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
        prio_q[i] <= '0;
        mode_q[i] <= '0;
        vec_q[i]  <= '0;
      end else begin
        pend_q[i] <= mode_q[i][0] & ((pend_q[i] & ~(take && win == SW'(i))) | ev[i]);
        if (cfg_we && cfg_src == SW'(i)) begin
          en_q[i]   <= cfg_en;
          prio_q[i] <= cfg_prio;
          mode_q[i] <= cfg_mode;
          vec_q[i]  <= cfg_vec;
        end
      end
    end
  end

  always_comb begin
    hit = 1'b0;
    win = '0;
    wp  = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (elig[i] && (!hit || prio_q[i] >= wp)) begin
        hit = 1'b1;
        win = SW'(i);
        wp  = prio_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int k = 0; k < NL; k++) stk_q[k] <= '0;
    end else if (pop) begin
      depth_q <= depth_q - DW'(1);
    end else if (take) begin
      stk_q[PW'(depth_q)] <= wp;
      depth_q <= depth_q + DW'(1);
    end
  end

  assign irq_o = hit;
  assign fiq_o = fiq_s;
  assign src_o = hit ? win : '0;
  assign vec_o = hit ? vec_q[win] : '0;

endmodule

// File: rtl/prio_vic_chk.sv
module prio_vic_chk #(
  parameter int NS = 8,
  parameter int NL = 8,
  parameter int VW = 16,
  parameter int SW = 4,
  parameter int PW = 3,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_fiq,
  input logic          fiq_o,
  input logic          irq_o,
  input logic [SW-1:0] src_o,
  input logic [VW-1:0] vec_o,
  input logic          ack,
  input logic          eoi,
  input logic [NS-1:0] en,
  input logic [DW-1:0] depth,
  input logic [PW-1:0] top_lvl,
  input logic [PW-1:0] win_prio
);

  a_r2_fiq_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(ext_fiq, 2));

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (src_o == '0 && vec_o == '0));

  a_r8_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (src_o < SW'(NS) && en[src_o]));

  a_r9_push: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !eoi && irq_o) |=> depth == $past(depth) + DW'(1));

  a_r9_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && depth != '0) |-> win_prio > top_lvl);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(NL));

  a_r10_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && depth != '0) |=> depth == $past(depth) - DW'(1));

  a_r10_empty_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && depth == '0) |=> depth == '0);

endmodule

bind prio_vic prio_vic_chk #(
  .NS(NS), .NL(NL), .VW(VW), .SW(SW), .PW(PW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_fiq(ext_fiq), .fiq_o(fiq_o),
  .irq_o(irq_o), .src_o(src_o), .vec_o(vec_o), .ack(ack), .eoi(eoi),
  .en(en_q), .depth(depth_q), .top_lvl(top_lvl), .win_prio(wp)
);

// File: tb/prio_vic_bench.sv
`timescale 1ns/1ps
module prio_vic_bench;
  localparam int NI = 6;
  localparam int NL = 8;
  localparam int VW = 16;
  localparam int NS = NI + 2;
  localparam int SW = $clog2(NS + 1);
  localparam int PW = $clog2(NL);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NI-1:0] per_irq = '0;
  logic [1:0]    ext_irq = '0;
  logic          ext_fiq = 1'b0;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_src = '0;
  logic          cfg_en = 1'b0;
  logic [PW-1:0] cfg_prio = '0;
  logic [1:0]    cfg_mode = '0;
  logic [VW-1:0] cfg_vec = '0;
  logic          ack = 1'b0, eoi = 1'b0;
  logic          irq_o, fiq_o;
  logic [SW-1:0] src_o;
  logic [VW-1:0] vec_o;

  prio_vic #(.NI(NI), .NL(NL), .VW(VW)) u_prio_vic (
    .clk(clk), .rst_n(rst_n), .per_irq(per_irq), .ext_irq(ext_irq), .ext_fiq(ext_fiq),
    .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
    .cfg_mode(cfg_mode), .cfg_vec(cfg_vec), .ack(ack), .eoi(eoi),
    .irq_o(irq_o), .fiq_o(fiq_o), .src_o(src_o), .vec_o(vec_o));

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  bit m_en[NS]; int m_prio[NS]; int m_mode[NS]; int m_vec[NS]; bit m_pend[NS];
  bit m_extm[2], m_exts[2], m_extd[2]; bit m_perd[NI]; bit m_fm, m_fs;
  int stk[$];

  function automatic bit cur_in(int i);
    return (i < NI) ? per_irq[i] : m_exts[i-NI];
  endfunction
  function automatic bit old_in(int i);
    return (i < NI) ? m_perd[i] : m_extd[i-NI];
  endfunction
  function automatic bit low_pol(int i);
    return (i >= NI) && ((m_mode[i] >> 1) & 1) == 1;
  endfunction

  function automatic int winner();
    int b = -1;
    for (int i = 0; i < NS; i++) begin
      bit r;
      r = (m_mode[i] & 1) ? m_pend[i] : (cur_in(i) ^ low_pol(i));
      if (r && m_en[i] && (stk.size() == 0 || m_prio[i] > stk[$]))
        if (b < 0 || m_prio[i] > m_prio[b]) b = i;
    end
    return b;
  endfunction

  task automatic cmp(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic check_now();
    int b = winner();
    cmp("irq_o", int'(irq_o), b >= 0);
    cmp("src_o", int'(src_o), b >= 0 ? b : 0);
    cmp("vec_o", int'(vec_o), b >= 0 ? m_vec[b] : 0);
    cmp("fiq_o", int'(fiq_o), int'(m_fs));
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        m_en[i] = 0; m_prio[i] = 0; m_mode[i] = 0; m_vec[i] = 0; m_pend[i] = 0;
      end
      m_extm = '{0, 0}; m_exts = '{0, 0}; m_extd = '{0, 0};
      for (int i = 0; i < NI; i++) m_perd[i] = 0;
      m_fm = 0; m_fs = 0; stk.delete();
    end else begin
      int b = winner();
      bit tk = ack && !eoi && b >= 0;
      bit np[NS];
      for (int i = 0; i < NS; i++) begin
        bit e;
        e = low_pol(i) ? (old_in(i) && !cur_in(i)) : (cur_in(i) && !old_in(i));
        np[i] = (m_mode[i] & 1) ? ((m_pend[i] && !(tk && b == i)) || e) : 0;
      end
      if (eoi && stk.size() > 0) void'(stk.pop_back());
      else if (tk) stk.push_back(m_prio[b]);
      for (int i = 0; i < NS; i++) m_pend[i] = np[i];
      if (cfg_we && int'(cfg_src) < NS) begin
        m_en[cfg_src] = cfg_en; m_prio[cfg_src] = cfg_prio;
        m_mode[cfg_src] = cfg_mode; m_vec[cfg_src] = cfg_vec;
      end
      m_extd = m_exts; m_exts = m_extm;
      m_extm[0] = ext_irq[0]; m_extm[1] = ext_irq[1];
      for (int i = 0; i < NI; i++) m_perd[i] = per_irq[i];
      m_fs = m_fm; m_fm = ext_fiq;
    end
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      #1 check_now();
      @(posedge clk);
      model_edge();
      @(negedge clk);
    end
  endtask

  task automatic cfg(int s, bit en, int pr, int md, int vc);
    cfg_we = 1; cfg_src = SW'(s); cfg_en = en; cfg_prio = PW'(pr);
    cfg_mode = 2'(md); cfg_vec = VW'(vc);
    step();
    cfg_we = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; step(); ack = 0;
  endtask
  task automatic pulse_eoi();
    eoi = 1; step(); eoi = 0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(posedge clk); model_edge(); @(negedge clk);
    tag = "R1"; step(3);
    rst_n = 1; step(2);

    tag = "R11";
    cfg(NS, 1, 7, 0, 16'hdead);
    cfg(NS + 1 < (1 << SW) ? NS + 1 : NS, 1, 7, 0, 16'hbeef);
    per_irq = '1; step(3); per_irq = '0; step();

    cfg(0, 1, 3, 0, 16'h0100);
    cfg(1, 1, 3, 0, 16'h0101);
    cfg(2, 1, 5, 1, 16'h0102);
    cfg(3, 1, 1, 3, 16'h0103);
    cfg(4, 1, 4, 0, 16'h0104);
    cfg(5, 0, 7, 0, 16'h0105);
    cfg(6, 1, 2, 1, 16'h0106);
    cfg(7, 1, 6, 2, 16'h0107);

    tag = "R8";  per_irq = 6'b100000; step(3);
    tag = "R4";  per_irq = 6'b000011; step(2);
    per_irq = 6'b010011; step(2); per_irq = '0; step();
    tag = "R6";  ext_irq[0] = 1; step(4); ext_irq[0] = 0; step(4);
    tag = "R7";  cfg(2, 0, 5, 1, 16'h0102);
    per_irq[2] = 1; step(); per_irq[2] = 0; step(2);
    cfg(2, 1, 5, 1, 16'h0102); step(2);
    pulse_ack(); step(); pulse_eoi(); step();
    tag = "R5";  per_irq[3] = 1; step(3); pulse_ack(); per_irq[3] = 0; step(); pulse_eoi();
    tag = "R6";  ext_irq[1] = 1; step(4); ext_irq[1] = 0; step(4);
    pulse_ack(); step(); pulse_eoi(); step();

    tag = "R9";
    pulse_ack(); step();
    per_irq[0] = 1; step(); pulse_ack();
    per_irq[1] = 1; step(2);
    per_irq[4] = 1; step(); pulse_ack(); step(2);
    tag = "R10";
    pulse_eoi(); step(); pulse_eoi(); step(); pulse_eoi(); pulse_eoi(); step();
    ack = 1; eoi = 1; step(); ack = 0; eoi = 0; step();
    per_irq = '0; step();
    tag = "R2";
    ext_fiq = 1; step(3); per_irq = '1; step(2); ext_fiq = 0; step(3); per_irq = '0; step();

    tag = "R3";
    for (int n = 0; n < 3000; n++) begin
      per_irq = NI'($urandom);
      if ($urandom % 6 == 0) ext_irq = 2'($urandom);
      if ($urandom % 5 == 0) ext_fiq = 1'($urandom);
      ack = ($urandom % 3 == 0);
      eoi = ($urandom % 7 == 0);
      if ($urandom % 40 == 0) begin
        cfg_we = 1; cfg_src = SW'($urandom % (NS + 2)); cfg_en = 1'($urandom);
        cfg_prio = PW'($urandom); cfg_mode = 2'($urandom); cfg_vec = VW'($urandom);
      end
      step();
      cfg_we = 0;
    end
    ack = 0; eoi = 0; step(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule